// File: doc/BRIEF.md
# Multi-Mode Prescaled Timer

This block is a 32-bit programmable timer held behind a small write/read register interface. A slow clock source is modelled as a `tick` enable. A prescaler divides those ticks by 32, 8, 4 or 2, and each resulting prescaled tick advances a counter. The counter is compared against a match value. On a match the timer raises a sticky interrupt and then does one of three things, set by the mode field: it keeps running and wraps at 2^32 (free run), it restarts from zero (periodic), or it stops and drops its own enable (one-shot).

Writes do not take effect at once. Each writable register has a synchroniser slot that holds the new value for two prescaled ticks, the same delay a crossing into a slow timer domain would cost. While a slot is waiting, its bit in the status word reads 1, so software polls until the status word is zero. Two write-only registers act on the timer when written. One drops the interrupt and the other zeroes the counter. The data written to either of them is ignored.

Register offsets (byte addresses): match 0x00, count 0x04, control 0x08, clear-interrupt 0x0C, clear-count 0x10, status 0x14. Control fields: bit 5 power-on, bit 4 count enable, bits 3:2 mode (0 free run, 1 one-shot, 2 periodic, 3 treated as free run), bits 1:0 prescale code (0 gives /32, 1 gives /8, 2 gives /4, 3 gives /2). Status bits: 4 match, 3 count, 2 control, 1 clear-interrupt, 0 clear-count.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, match, count and control read 0, the status word reads 0 and `irq` is 0.
- R2: A write to offset 0x00, 0x04, 0x08, 0x0C or 0x10 sets status bit 4, 3, 2, 1 or 0 from the next cycle. The write takes effect on the second prescaled tick that follows the write cycle, and the status bit clears in the same update. Until then, readback shows the old value.
- R3: With prescale code 0, 1, 2 or 3 in control bits 1:0, a prescaled tick occurs once every 32, 8, 4 or 2 cycles in which `tick` is high. Cycles with `tick` low are not counted.
- R4: The counter advances by one on a prescaled tick only when control bit 5 (on) and bit 4 (enable) are both 1.
- R5: In free-run mode (mode 0 or 3), reaching the match value sets the interrupt and the counter carries on, wrapping from 0xFFFFFFFF to 0.
- R6: In periodic mode (mode 2), the increment that reaches the match value loads 0 into the counter instead, and the counter keeps running.
- R7: In one-shot mode (mode 1), the counter stops at the match value and control bit 4 reads 0 afterwards.
- R8: `irq` stays 1 from a match until a clear-interrupt write takes effect. If that clear lands on the same prescaled tick as a match, `irq` stays 1.
- R9: When a clear-count write takes effect, the counter becomes 0. This overrides counting and any count write landing on the same tick.
- R10: A second write to the same register while its first write is still pending discards the first value and restarts the two-tick wait with the new data.
- R11: The data written to the clear registers is ignored. Reads at 0x0C, 0x10 and any unmapped offset return 0, and writes to unmapped or misaligned offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer clock-source enable, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Byte offset of the combinational read |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Sticky match interrupt |

## Verification
Several slots, and the counter's own match, can all land on one prescaled tick. The cases that matter most are a clear-interrupt landing on the tick that produces a match, and a clear-count landing with a count write or an increment. To provoke these, the bench issues clear-interrupt writes at every offset of a short periodic cycle, and issues count and clear-count writes in back-to-back cycles so that both fall inside one prescale window. A behavioural model applies the stated priorities (match beats clear, clear-count beats count write beats increment, a control write beats the one-shot enable drop) and is compared against `irq`, the status word and the readback on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int PSC_W   = 5;
  localparam int N_SLOTS = 5;
  localparam int CTRL_W  = 6;

  // slot index equals its status bit
  localparam int SL_CLRCNT = 0;
  localparam int SL_CLRIRQ = 1;
  localparam int SL_CTRL   = 2;
  localparam int SL_COUNT  = 3;
  localparam int SL_MATCH  = 4;

  localparam logic [4:0] OFS_MATCH  = 5'h00;
  localparam logic [4:0] OFS_COUNT  = 5'h04;
  localparam logic [4:0] OFS_CTRL   = 5'h08;
  localparam logic [4:0] OFS_CLRIRQ = 5'h0C;
  localparam logic [4:0] OFS_CLRCNT = 5'h10;
  localparam logic [4:0] OFS_STATUS = 5'h14;

  typedef enum logic [1:0] {
    MODE_FREE   = 2'd0,
    MODE_ONCE   = 2'd1,
    MODE_PERIOD = 2'd2,
    MODE_FREE_B = 2'd3
  } run_mode_e;

  // terminal value of the prescale counter (divisor minus one)
  function automatic logic [PSC_W-1:0] psc_last(input logic [1:0] code);
    case (code)
      2'd0:    psc_last = PSC_W'(31);
      2'd1:    psc_last = PSC_W'(7);
      2'd2:    psc_last = PSC_W'(3);
      default: psc_last = PSC_W'(1);
    endcase
  endfunction

  function automatic logic [4:0] slot_offset(input int s);
    case (s)
      SL_CLRCNT: slot_offset = OFS_CLRCNT;
      SL_CLRIRQ: slot_offset = OFS_CLRIRQ;
      SL_CTRL:   slot_offset = OFS_CTRL;
      SL_COUNT:  slot_offset = OFS_COUNT;
      default:   slot_offset = OFS_MATCH;
    endcase
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] code,
  output logic       pre_tick
);

  logic [PSC_W-1:0] psc_q;
  logic             at_last;

  assign at_last  = (psc_q >= psc_last(code));
  assign pre_tick = tick && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        psc_q <= '0;
    else if (pre_tick) psc_q <= '0;
    else if (tick)     psc_q <= psc_q + PSC_W'(1);
  end

  // R3: the smallest divisor is 2, so two prescaled ticks never fall in adjacent cycles
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |=> !pre_tick);

endmodule

// File: rtl/tmr_sync_slot.sv
module tmr_sync_slot #(
  parameter int DW   = 32,
  parameter int WAIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          pre_tick,
  output logic          busy,
  output logic          fire,
  output logic [DW-1:0] held
);

  localparam int CW = $clog2(WAIT + 1);

  logic [CW-1:0] left_q;

  assign busy = (left_q != '0);
  assign fire = pre_tick && !wr && (left_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      held   <= '0;
    end else if (wr) begin
      left_q <= CW'(WAIT);
      held   <= wdata;
    end else if (pre_tick && busy) begin
      left_q <= left_q - CW'(1);
    end
  end

  // R2 / R10: any write (fresh or repeated) leaves the slot busy
  a_r2_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> busy);
  // R2: the landing tick ends the pending state
  a_r2_fire_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !busy);
  // R2: without a prescaled tick or write the pending state does not move
  a_r2_busy_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !pre_tick) |=> $stable(busy));

endmodule

// File: rtl/tmr_counter_core.sv
module tmr_counter_core
  import tmr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_tick,
  input  logic              fire_match,
  input  logic              fire_count,
  input  logic              fire_ctrl,
  input  logic              fire_clrirq,
  input  logic              fire_clrcnt,
  input  logic [DW-1:0]     new_match,
  input  logic [DW-1:0]     new_count,
  input  logic [CTRL_W-1:0] new_ctrl,
  output logic [DW-1:0]     match_q,
  output logic [DW-1:0]     count_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              irq_q
);

  localparam int BIT_ON = 5;
  localparam int BIT_EN = 4;

  run_mode_e     mode;
  logic          run;
  logic          hit;
  logic [DW-1:0] cnt_inc;
  logic [DW-1:0] count_d;
  logic [CTRL_W-1:0] ctrl_d;

  assign mode    = run_mode_e'(ctrl_q[3:2]);
  assign run     = pre_tick && ctrl_q[BIT_ON] && ctrl_q[BIT_EN];
  assign cnt_inc = count_q + DW'(1);
  assign hit     = run && (cnt_inc == match_q);

  always_comb begin
    count_d = count_q;
    if (fire_clrcnt)                        count_d = '0;
    else if (fire_count)                    count_d = new_count;
    else if (run) begin
      if (hit && mode == MODE_PERIOD)       count_d = '0;
      else                                  count_d = cnt_inc;
    end
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (fire_ctrl)                          ctrl_d = new_ctrl;
    else if (hit && mode == MODE_ONCE)      ctrl_d[BIT_EN] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      count_q <= '0;
      ctrl_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      ctrl_q  <= ctrl_d;
      if (fire_match)       match_q <= new_match;
      if (hit)              irq_q   <= 1'b1;
      else if (fire_clrirq) irq_q   <= 1'b0;
    end
  end

  // R4: no increment, no landing write -> counter holds
  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !fire_clrcnt && !fire_count) |=> $stable(count_q));
  // R8: interrupt only drops through a landing clear
  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !fire_clrirq) |=> irq_q);
  // R7: one-shot match drops the enable unless a control write lands
  a_r7_once_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == MODE_ONCE && !fire_ctrl) |=> !ctrl_q[BIT_EN]);
  // R6: periodic match reloads zero
  a_r6_period_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == MODE_PERIOD && !fire_clrcnt && !fire_count) |=> (count_q == '0));
  // R9: a landing clear-count always yields zero
  a_r9_clear_count: assert property (@(posedge clk) disable iff (!rst_n)
    fire_clrcnt |=> (count_q == '0));

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
#(
  parameter int DW        = 32,
  parameter int SYNC_WAIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [4:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [4:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          irq
);

  logic                pre_tick;
  logic [N_SLOTS-1:0]  slot_wr;
  logic [N_SLOTS-1:0]  slot_busy;
  logic [N_SLOTS-1:0]  slot_fire;
  logic [DW-1:0]       slot_val [N_SLOTS];

  logic [DW-1:0]       match_q;
  logic [DW-1:0]       count_q;
  logic [CTRL_W-1:0]   ctrl_q;

  tmr_prescaler u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .code     (ctrl_q[1:0]),
    .pre_tick (pre_tick)
  );

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    assign slot_wr[s] = wr_en && (wr_addr == slot_offset(s));

    tmr_sync_slot #(.DW(DW), .WAIT(SYNC_WAIT)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (slot_wr[s]),
      .wdata    (wr_data),
      .pre_tick (pre_tick),
      .busy     (slot_busy[s]),
      .fire     (slot_fire[s]),
      .held     (slot_val[s])
    );
  end

  tmr_counter_core #(.DW(DW)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .pre_tick    (pre_tick),
    .fire_match  (slot_fire[SL_MATCH]),
    .fire_count  (slot_fire[SL_COUNT]),
    .fire_ctrl   (slot_fire[SL_CTRL]),
    .fire_clrirq (slot_fire[SL_CLRIRQ]),
    .fire_clrcnt (slot_fire[SL_CLRCNT]),
    .new_match   (slot_val[SL_MATCH]),
    .new_count   (slot_val[SL_COUNT]),
    .new_ctrl    (slot_val[SL_CTRL][CTRL_W-1:0]),
    .match_q     (match_q),
    .count_q     (count_q),
    .ctrl_q      (ctrl_q),
    .irq_q       (irq)
  );

  always_comb begin
    case (rd_addr)
      OFS_MATCH:  rd_data = match_q;
      OFS_COUNT:  rd_data = count_q;
      OFS_CTRL:   rd_data = {{(DW-CTRL_W){1'b0}}, ctrl_q};
      OFS_STATUS: rd_data = {{(DW-N_SLOTS){1'b0}}, slot_busy};
      default:    rd_data = '0;
    endcase
  end

  // R11: a write outside the decoded offsets arms no slot
  a_r11_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != OFS_MATCH && wr_addr != OFS_COUNT && wr_addr != OFS_CTRL &&
     wr_addr != OFS_CLRIRQ && wr_addr != OFS_CLRCNT) |=> ($countones(slot_busy) <= $countones($past(slot_busy))));
  // R2: at most one slot is written per cycle
  a_r2_single_slot_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_wr));

endmodule

// File: tb/prescaled_timer_bench.sv
module prescaled_timer_bench;

  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  prescaled_timer u_prescaled_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #(CLK_PER/2) clk = ~clk;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 0;
  int    tick_gap = 1;   // tick high once every tick_gap cycles

  // ---------------- behavioural reference ----------------
  longint m_match, m_count, m_ctrl, m_psc;
  bit     m_irq;
  int     m_left [5];   // index = status bit
  longint m_val  [5];

  function automatic int which_slot(input logic [4:0] a);
    if (a == 5'h10) return 0;
    if (a == 5'h0C) return 1;
    if (a == 5'h08) return 2;
    if (a == 5'h04) return 3;
    if (a == 5'h00) return 4;
    return -1;
  endfunction

  function automatic int divisor(input longint c);
    case (c & 3)
      0: return 32;
      1: return 8;
      2: return 4;
      default: return 2;
    endcase
  endfunction

  function automatic longint model_read(input logic [4:0] a);
    longint st = 0;
    for (int i = 0; i < 5; i++) if (m_left[i] > 0) st |= (64'd1 << i);
    case (a)
      5'h00: return m_match;
      5'h04: return m_count;
      5'h08: return m_ctrl;
      5'h14: return st;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_match = 0; m_count = 0; m_ctrl = 0; m_psc = 0; m_irq = 0;
      for (int i = 0; i < 5; i++) begin m_left[i] = 0; m_val[i] = 0; end
    end else begin
      bit     pt, going, matched;
      bit     lands [5];
      int     ws;
      longint nxt, n_count, n_ctrl;
      int     mode;
      ws    = wr_en ? which_slot(wr_addr) : -1;
      pt    = tick && (m_psc + 1 >= divisor(m_ctrl));
      if (tick) m_psc = pt ? 0 : m_psc + 1;
      for (int i = 0; i < 5; i++) lands[i] = pt && (ws != i) && (m_left[i] == 1);
      mode    = int'((m_ctrl >> 2) & 3);
      going   = pt && ((m_ctrl >> 5) & 1) != 0 && ((m_ctrl >> 4) & 1) != 0;
      nxt     = (m_count + 1) & 64'hFFFF_FFFF;
      matched = going && (nxt == m_match);
      n_count = m_count;
      if (going) n_count = (matched && mode == 2) ? 0 : nxt;
      if (lands[3]) n_count = m_val[3];
      if (lands[0]) n_count = 0;
      n_ctrl = m_ctrl;
      if (matched && mode == 1) n_ctrl = m_ctrl & ~64'h10;
      if (lands[2]) n_ctrl = m_val[2] & 64'h3F;
      if (lands[4]) m_match = m_val[4];
      if (lands[1]) m_irq = 0;
      if (matched)  m_irq = 1;
      m_count = n_count;
      m_ctrl  = n_ctrl;
      for (int i = 0; i < 5; i++) begin
        if (ws == i) begin m_left[i] = 2; m_val[i] = longint'(wr_data); end
        else if (pt && m_left[i] > 0) m_left[i]--;
      end
    end
  end

  // ---------------- stimulus side: tick and read address rotation ----------------
  int cyc = 0;
  always @(negedge clk) begin
    logic [4:0] seq [7] = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h18};
    cyc++;
    tick    <= (cyc % tick_gap) == 0;
    rd_addr <= seq[cyc % 7];
  end

  // ---------------- per-cycle comparison ----------------
  always begin
    @(negedge clk);
    #(CLK_PER/4);
    if (rst_n && !done) begin
      n_vec++;
      if (irq !== m_irq) begin
        n_bad++;
        $display("FAIL %s irq: got %0b expected %0b (t=%0t)", cur_req, irq, m_irq, $time);
      end
      if (rd_data !== 32'(model_read(rd_addr))) begin
        n_bad++;
        $display("FAIL %s read @%h: got %h expected %h (t=%0t)", cur_req, rd_addr,
                 rd_data, 32'(model_read(rd_addr)), $time);
      end
    end
  end

  task automatic put(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en <= 1'b1; wr_addr <= a; wr_data <= d;
    @(negedge clk);
    wr_en <= 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // named check of one register at a quiet moment
  task automatic peek(input string req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    #(CLK_PER/8);
    force rd_addr = a;
    #1;
    n_vec++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s peek @%h: got %h expected %h", req, a, rd_data, exp);
    end
    release rd_addr;
  endtask

  initial begin
    idle(5);
    rst_n = 1'b1;
    // R1: reset state
    cur_req = "R1";
    peek("R1", 5'h08, 32'h0);
    peek("R1", 5'h14, 32'h0);
    idle(5);

    // R2: match write lands after two /32 prescaled ticks
    cur_req = "R2";
    put(5'h00, 32'd20);
    peek("R2", 5'h14, 32'h10);
    idle(80);
    peek("R2", 5'h00, 32'd20);

    // R4: on without enable, then enable without on
    cur_req = "R4";
    put(5'h08, 32'h23); idle(80);
    put(5'h08, 32'h13); idle(20);
    peek("R4", 5'h04, 32'd0);

    // R5 and R3: free run at /2 past the match
    cur_req = "R5";
    put(5'h08, 32'h33); idle(80);
    cur_req = "R8";
    put(5'h0C, 32'hDEAD_BEEF); idle(10);
    cur_req = "R3";
    put(5'h08, 32'h30); idle(120);
    put(5'h08, 32'h31); idle(80);
    put(5'h08, 32'h32); idle(60);

    // R9: count write then clear-count in back-to-back cycles
    cur_req = "R9";
    put(5'h04, 32'd500);
    put(5'h10, 32'h0);
    idle(30);
    put(5'h10, 32'h1234); put(5'h04, 32'd9); idle(30);

    // R10: rewrite of a pending match
    cur_req = "R10";
    put(5'h00, 32'd100);
    put(5'h00, 32'd7);
    idle(30);
    peek("R10", 5'h00, 32'd7);

    // R6: periodic at /4, match 7
    cur_req = "R6";
    put(5'h10, 32'h0);
    put(5'h08, 32'h3A);
    idle(200);

    // R8: clear-interrupt at every phase of the period
    cur_req = "R8";
    for (int k = 0; k < 12; k++) begin
      put(5'h0C, 32'h0);
      idle(k);
    end
    idle(40);

    // R7: one-shot at /4 stops at 7 and drops enable
    cur_req = "R7";
    put(5'h10, 32'h0);
    put(5'h08, 32'h36);
    idle(120);
    peek("R7", 5'h04, 32'd7);
    peek("R7", 5'h08, 32'h26);

    // R11: unmapped and misaligned writes, clear-register reads
    cur_req = "R11";
    put(5'h18, 32'hFFFF_FFFF);
    put(5'h09, 32'hFFFF_FFFF);
    peek("R11", 5'h14, 32'h0);
    peek("R11", 5'h0C, 32'h0);
    peek("R11", 5'h10, 32'h0);

    // R3: sparse tick enable, periodic at /2
    cur_req = "R3";
    tick_gap = 3;
    put(5'h0C, 32'h0);
    put(5'h10, 32'h0);
    put(5'h08, 32'h3B);
    idle(150);
    tick_gap = 1;
    idle(5);

    // R5: wrap through zero with match 0
    cur_req = "R5";
    put(5'h08, 32'h23);
    idle(20);
    put(5'h04, 32'hFFFF_FFF0);
    put(5'h00, 32'h0);
    put(5'h0C, 32'h0);
    idle(20);
    put(5'h08, 32'h33);
    idle(80);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule